// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block observes the two lines of an I2C bus and the optional SMBus alert line. It decodes START and STOP conditions and keeps a bus-busy level. It also tracks the position inside each 9-clock frame, so that a START or STOP arriving in the middle of a frame can be reported as a bus error when this node takes part in the transfer. The surrounding controller supplies status inputs: its role, whether it drove the STOP itself, whether it has been addressed, whether a slave address phase is in progress, and the two SMBus alert enables. The monitor uses these to decide which events concern this node.

The lines pass through a parameterised synchronizer. A one-register edge history follows it, then a combinational condition decoder. A three-state machine sits at the centre. `MON_OFF` is held while the enable input is low. `MON_FREE` means the bus is idle. `MON_BUSY` covers a transfer. The transitions are T_ENABLE (OFF to FREE), T_START (FREE to BUSY on a START), T_RESTART (BUSY to BUSY on a repeated START, which also resets the frame position), T_STOP (BUSY to FREE on a STOP) and T_DISABLE (any state to OFF when the enable is low). Every output except busy is a registered pulse one cycle long. When SMBus support is left out by parameter, the alert output is a constant 0.

Top module: `i2c_cond_monitor`

## Requirements
- R1: A falling SDA while SCL is high and was high in the previous synchronized sample produces a one-cycle `start_o` pulse. With the default two synchronizer stages, the pulse is high in the cycle after the third rising clock edge that follows the line change.
- R2: A rising SDA while SCL is high produces a one-cycle `stop_o` pulse with the same latency as R1.
- R3: `busy_o` rises together with the `start_o` pulse of a START seen on an idle bus. It stays high through repeated STARTs and falls together with the `stop_o` pulse.
- R4: While `en_i` is 0, `busy_o` and every pulse output are 0 from the next cycle onward. Line activity during that time has no effect, and after re-enabling the bus is reported idle.
- R5: Frame position counts SCL falling edges modulo 9. A START resets it to 0 and makes the first SCL fall after that START uncounted, so a START or STOP after a multiple of 9 data clocks is at position 0.
- R6: `bus_err_o` pulses together with `start_o` or `stop_o` when the condition arrives during a transfer at a nonzero frame position and the node is involved. The node is involved when it is master, or when it is slave and is addressed now or was addressed earlier in the transfer.
- R7: No bus error is reported while the node is slave and `addr_phase_i` is 1.
- R8: As master, `stop_self_o` pulses with `stop_o` only when `stop_by_self_i` is 1.
- R9: As slave, `stop_self_o` pulses with `stop_o` when `addressed_i` was 1 at any cycle since the transfer began. The record clears when the transfer ends.
- R10: `alert_o` pulses once on a falling edge of `alert_n_i` only when both `smb_host_en_i` and `alert_en_i` are 1. A rising edge never produces a pulse.
- R11: With parameter `SMBUS_EN` = 0, `alert_o` stays 0 whatever the alert line does.
- R12: No pulse output stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Peripheral enable; 0 clears all state |
| scl_i | input | 1 | Filtered SCL line |
| sda_i | input | 1 | Filtered SDA line |
| alert_n_i | input | 1 | SMBus alert line, active low |
| is_master_i | input | 1 | 1 when the node acts as master |
| stop_by_self_i | input | 1 | 1 when the node generated the current STOP |
| addressed_i | input | 1 | 1 when the node's slave address has matched |
| addr_phase_i | input | 1 | 1 during the slave address phase |
| smb_host_en_i | input | 1 | SMBus host configuration enable |
| alert_en_i | input | 1 | Alert detection enable |
| start_o | output | 1 | START detected pulse |
| stop_o | output | 1 | STOP detected pulse |
| stop_self_o | output | 1 | STOP relevant to this node pulse |
| bus_err_o | output | 1 | Misplaced START/STOP pulse |
| alert_o | output | 1 | Alert falling edge pulse |
| busy_o | output | 1 | Bus busy level |

## Verification
The hardest situation to reach is a misplaced condition that must still be reported for a slave. The node has to be addressed at some point inside the transfer, the address input must then drop, and a STOP must follow at a nonzero frame position. Only the remembered involvement can then make the error visible. The stimulus drives whole SCL data clocks of chosen counts between START and STOP. It changes the status inputs between those groups, so frame positions 2, 3, 4 and 5 and the frame boundary are each reached under different role and address histories. Repeated STARTs at mid-frame and at frame boundaries are driven the same way.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    typedef enum logic [1:0] {
        MON_OFF  = 2'd0,
        MON_FREE = 2'd1,
        MON_BUSY = 2'd2
    } mon_state_e;

    localparam int LINE_SCL   = 0;
    localparam int LINE_SDA   = 1;
    localparam int LINE_ALERT = 2;
    localparam int LINE_COUNT = 3;

endpackage

// File: rtl/icm_line_sync.sv
module icm_line_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [WIDTH-1:0] stage_in;
        if (g == 0) begin : g_first
            assign stage_in = din_i;
        end else begin : g_next
            assign stage_in = stage_q[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= RST_VAL;
            end else if (!en_i) begin
                stage_q[g] <= RST_VAL;
            end else begin
                stage_q[g] <= stage_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else if (!en_i) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
    assign prev_o = prev_q;

endmodule

// File: rtl/icm_edge_decode.sv
module icm_edge_decode (
    input  logic scl_now_i,
    input  logic scl_old_i,
    input  logic sda_now_i,
    input  logic sda_old_i,
    output logic start_det_o,
    output logic stop_det_o,
    output logic scl_fall_o
);

    logic scl_held_high;

    always_comb begin
        scl_held_high = scl_now_i & scl_old_i;
        start_det_o   = scl_held_high & sda_old_i & ~sda_now_i;
        stop_det_o    = scl_held_high & ~sda_old_i & sda_now_i;
        scl_fall_o    = scl_old_i & ~scl_now_i;
    end

endmodule

// File: rtl/icm_alert_det.sv
module icm_alert_det (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic al_now_i,
    input  logic al_old_i,
    input  logic host_en_i,
    input  logic alert_en_i,
    output logic alert_o
);

    logic fall_seen;
    logic alert_q;

    assign fall_seen = al_old_i & ~al_now_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alert_q <= 1'b0;
        end else if (!en_i) begin
            alert_q <= 1'b0;
        end else begin
            alert_q <= fall_seen & host_en_i & alert_en_i;
        end
    end

    assign alert_o = alert_q;

    // R10: an alert pulse needs both enables in the sampled cycle
    a_r10_alert_gated: assert property (@(posedge clk) disable iff (!rst_n)
        alert_o |-> $past(host_en_i && alert_en_i));

    // R12: alert pulse lasts one cycle
    a_r12_alert_single: assert property (@(posedge clk) disable iff (!rst_n)
        alert_o |=> !alert_o);

endmodule

// File: rtl/icm_frame_fsm.sv
module icm_frame_fsm
    import i2c_cond_pkg::*;
#(
    parameter int BITS_PER_FRAME = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic start_det_i,
    input  logic stop_det_i,
    input  logic scl_fall_i,
    input  logic is_master_i,
    input  logic stop_by_self_i,
    input  logic addressed_i,
    input  logic addr_phase_i,
    output logic start_o,
    output logic stop_o,
    output logic stop_self_o,
    output logic bus_err_o,
    output logic busy_o
);

    localparam int             CNT_W = $clog2(BITS_PER_FRAME) + 1;
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(BITS_PER_FRAME - 1);

    mon_state_e       state_q, state_d;
    logic [CNT_W-1:0] pos_q;
    logic             skip_q;
    logic             addr_seen_q;

    logic involved;
    logic err_masked;
    logic misplaced;
    logic self_stop;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MON_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: T_DISABLE, T_ENABLE, T_START, T_RESTART, T_STOP
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = MON_OFF;
        end else begin
            unique case (state_q)
                MON_OFF:  state_d = MON_FREE;
                MON_FREE: if (start_det_i) state_d = MON_BUSY;
                MON_BUSY: if (stop_det_i)  state_d = MON_FREE;
                default:  state_d = MON_OFF;
            endcase
        end
    end

    // frame position and involvement record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q       <= '0;
            skip_q      <= 1'b1;
            addr_seen_q <= 1'b0;
        end else begin
            if (state_d != MON_BUSY || start_det_i) begin
                pos_q  <= '0;
                skip_q <= 1'b1;
            end else if (scl_fall_i) begin
                if (skip_q) begin
                    skip_q <= 1'b0;
                end else if (pos_q == LAST) begin
                    pos_q <= '0;
                end else begin
                    pos_q <= pos_q + CNT_W'(1);
                end
            end

            if (state_d != MON_BUSY) begin
                addr_seen_q <= 1'b0;
            end else if (addressed_i) begin
                addr_seen_q <= 1'b1;
            end
        end
    end

    always_comb begin
        involved   = is_master_i | addr_seen_q | addressed_i;
        err_masked = ~is_master_i & addr_phase_i;
        misplaced  = (start_det_i | stop_det_i) & (state_q == MON_BUSY)
                   & (pos_q != '0) & involved & ~err_masked;
        self_stop  = stop_det_i & (is_master_i ? stop_by_self_i
                                               : (addr_seen_q | addressed_i));
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_o     <= 1'b0;
            stop_o      <= 1'b0;
            stop_self_o <= 1'b0;
            bus_err_o   <= 1'b0;
            busy_o      <= 1'b0;
        end else if (!en_i) begin
            start_o     <= 1'b0;
            stop_o      <= 1'b0;
            stop_self_o <= 1'b0;
            bus_err_o   <= 1'b0;
            busy_o      <= 1'b0;
        end else begin
            start_o     <= start_det_i;
            stop_o      <= stop_det_i;
            stop_self_o <= self_stop;
            bus_err_o   <= misplaced;
            busy_o      <= (state_d == MON_BUSY);
        end
    end

    a_r3_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> busy_o);

    a_r3_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !busy_o);

    a_r4_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!busy_o && !start_o && !stop_o && !bus_err_o && !stop_self_o));

    a_r5_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= LAST);

    a_r6_err_on_condition: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_o |-> (start_o || stop_o));

    a_r7_no_err_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_o |-> !$past(!is_master_i && addr_phase_i));

    a_r8_self_stop_is_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_self_o |-> stop_o);

    a_r12_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    a_r12_stop_single: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o);

endmodule

// File: rtl/i2c_cond_monitor.sv
module i2c_cond_monitor
    import i2c_cond_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int BITS_PER_FRAME = 9,
    parameter bit SMBUS_EN       = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic scl_i,
    input  logic sda_i,
    input  logic alert_n_i,
    input  logic is_master_i,
    input  logic stop_by_self_i,
    input  logic addressed_i,
    input  logic addr_phase_i,
    input  logic smb_host_en_i,
    input  logic alert_en_i,
    output logic start_o,
    output logic stop_o,
    output logic stop_self_o,
    output logic bus_err_o,
    output logic alert_o,
    output logic busy_o
);

    logic [LINE_COUNT-1:0] lines_raw;
    logic [LINE_COUNT-1:0] lines_now;
    logic [LINE_COUNT-1:0] lines_old;
    logic start_det, stop_det, scl_fall;

    always_comb begin
        lines_raw             = '1;
        lines_raw[LINE_SCL]   = scl_i;
        lines_raw[LINE_SDA]   = sda_i;
        lines_raw[LINE_ALERT] = alert_n_i;
    end

    icm_line_sync #(
        .WIDTH  (LINE_COUNT),
        .STAGES (SYNC_STAGES),
        .RST_VAL('1)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (en_i),
        .din_i (lines_raw),
        .sync_o(lines_now),
        .prev_o(lines_old)
    );

    icm_edge_decode decode_i (
        .scl_now_i  (lines_now[LINE_SCL]),
        .scl_old_i  (lines_old[LINE_SCL]),
        .sda_now_i  (lines_now[LINE_SDA]),
        .sda_old_i  (lines_old[LINE_SDA]),
        .start_det_o(start_det),
        .stop_det_o (stop_det),
        .scl_fall_o (scl_fall)
    );

    icm_frame_fsm #(
        .BITS_PER_FRAME(BITS_PER_FRAME)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_i          (en_i),
        .start_det_i   (start_det),
        .stop_det_i    (stop_det),
        .scl_fall_i    (scl_fall),
        .is_master_i   (is_master_i),
        .stop_by_self_i(stop_by_self_i),
        .addressed_i   (addressed_i),
        .addr_phase_i  (addr_phase_i),
        .start_o       (start_o),
        .stop_o        (stop_o),
        .stop_self_o   (stop_self_o),
        .bus_err_o     (bus_err_o),
        .busy_o        (busy_o)
    );

    if (SMBUS_EN) begin : g_smb
        icm_alert_det alert_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (en_i),
            .al_now_i  (lines_now[LINE_ALERT]),
            .al_old_i  (lines_old[LINE_ALERT]),
            .host_en_i (smb_host_en_i),
            .alert_en_i(alert_en_i),
            .alert_o   (alert_o)
        );
    end else begin : g_no_smb
        logic unused_alert_bits;
        assign unused_alert_bits = ^{lines_now[LINE_ALERT], lines_old[LINE_ALERT],
                                     smb_host_en_i, alert_en_i};
        assign alert_o = 1'b0;

        // R11: alert tied low without SMBus support
        a_r11_alert_tied: assert property (@(posedge clk) disable iff (!rst_n)
            !alert_o);
    end

endmodule

// File: tb/i2c_cond_monitor_tb_top.sv
module i2c_cond_monitor_tb_top;

    localparam logic [1:0] OP_START = 2'd0;
    localparam logic [1:0] OP_STOP  = 2'd1;
    localparam logic [1:0] OP_BITS  = 2'd2;
    localparam logic [1:0] OP_ALERT = 2'd3;

    typedef struct packed {
        logic [1:0] op;
        logic [3:0] nbits;
        logic m, sbu, adr, aph, host, alen;
        logic e_st, e_sp, e_sfu, e_be, e_al, e_busy;
    } vec_t;

    localparam int NVEC = 37;
    // op, nbits, master, stop_by_self, addressed, addr_phase, host, alert_en,
    // exp start, stop, stop_self, bus_err, alert, busy
    localparam vec_t VEC [NVEC] = '{
        '{OP_START, 4'd0, 0,0,0,0,0,0, 1,0,0,0,0,1}, // R1 R3
        '{OP_BITS,  4'd9, 0,0,0,1,0,0, 0,0,0,0,0,1},
        '{OP_STOP,  4'd0, 0,0,0,0,0,0, 0,1,0,0,0,0}, // R2 R9 not addressed
        '{OP_START, 4'd0, 1,0,0,0,0,0, 1,0,0,0,0,1},
        '{OP_BITS,  4'd9, 1,0,0,0,0,0, 0,0,0,0,0,1},
        '{OP_STOP,  4'd0, 1,1,0,0,0,0, 0,1,1,0,0,0}, // R8 own stop
        '{OP_START, 4'd0, 1,0,0,0,0,0, 1,0,0,0,0,1},
        '{OP_BITS,  4'd9, 1,0,0,0,0,0, 0,0,0,0,0,1},
        '{OP_STOP,  4'd0, 1,0,0,0,0,0, 0,1,0,0,0,0}, // R8 foreign stop
        '{OP_START, 4'd0, 0,0,0,0,0,0, 1,0,0,0,0,1},
        '{OP_BITS,  4'd9, 0,0,1,0,0,0, 0,0,0,0,0,1},
        '{OP_BITS,  4'd9, 0,0,0,0,0,0, 0,0,0,0,0,1},
        '{OP_STOP,  4'd0, 0,0,0,0,0,0, 0,1,1,0,0,0}, // R9 sticky address
        '{OP_START, 4'd0, 1,0,0,0,0,0, 1,0,0,0,0,1},
        '{OP_BITS,  4'd3, 1,0,0,0,0,0, 0,0,0,0,0,1},
        '{OP_START, 4'd0, 1,0,0,0,0,0, 1,0,0,1,0,1}, // R6 mid-frame restart
        '{OP_BITS,  4'd9, 1,0,0,0,0,0, 0,0,0,0,0,1},
        '{OP_STOP,  4'd0, 1,1,0,0,0,0, 0,1,1,0,0,0}, // R5 reset by restart
        '{OP_START, 4'd0, 0,0,1,1,0,0, 1,0,0,0,0,1},
        '{OP_BITS,  4'd4, 0,0,1,1,0,0, 0,0,0,0,0,1},
        '{OP_STOP,  4'd0, 0,0,1,1,0,0, 0,1,1,0,0,0}, // R7 masked
        '{OP_START, 4'd0, 1,0,0,0,0,0, 1,0,0,0,0,1},
        '{OP_BITS,  4'd5, 1,0,0,0,0,0, 0,0,0,0,0,1},
        '{OP_STOP,  4'd0, 1,1,0,0,0,0, 0,1,1,1,0,0}, // R6 mid-frame stop
        '{OP_START, 4'd0, 0,0,0,0,0,0, 1,0,0,0,0,1},
        '{OP_BITS,  4'd2, 0,0,1,0,0,0, 0,0,0,0,0,1},
        '{OP_STOP,  4'd0, 0,0,0,0,0,0, 0,1,1,1,0,0}, // R6 R9 remembered slave
        '{OP_START, 4'd0, 0,0,0,0,0,0, 1,0,0,0,0,1},
        '{OP_BITS,  4'd2, 0,0,0,0,0,0, 0,0,0,0,0,1},
        '{OP_STOP,  4'd0, 0,0,0,0,0,0, 0,1,0,0,0,0}, // R6 not involved
        '{OP_ALERT, 4'd0, 0,0,0,0,1,1, 0,0,0,0,1,0}, // R10
        '{OP_ALERT, 4'd0, 0,0,0,0,1,0, 0,0,0,0,0,0}, // R10
        '{OP_ALERT, 4'd0, 0,0,0,0,0,1, 0,0,0,0,0,0}, // R10
        '{OP_START, 4'd0, 1,0,0,0,0,0, 1,0,0,0,0,1},
        '{OP_BITS,  4'd9, 1,0,0,0,0,0, 0,0,0,0,0,1},
        '{OP_START, 4'd0, 1,0,0,0,0,0, 1,0,0,0,0,1}, // R5 boundary restart
        '{OP_STOP,  4'd0, 1,1,0,0,0,0, 0,1,1,0,0,0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic scl = 1'b1, sda = 1'b1, aln = 1'b1;
    logic m = 1'b0, sbu = 1'b0, adr = 1'b0, aph = 1'b0, host = 1'b0, alen = 1'b0;

    logic start_o, stop_o, stop_self_o, bus_err_o, alert_o, busy_o;
    logic n_start_o, n_stop_o, n_stop_self_o, n_bus_err_o, n_alert_o, n_busy_o;

    int checks = 0;
    int errors = 0;
    logic mon_on = 1'b0;
    int c_st, c_sp, c_sfu, c_be, c_al;
    int c_nosmb_al = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_cond_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .scl_i(scl), .sda_i(sda),
        .alert_n_i(aln), .is_master_i(m), .stop_by_self_i(sbu),
        .addressed_i(adr), .addr_phase_i(aph), .smb_host_en_i(host),
        .alert_en_i(alen), .start_o(start_o), .stop_o(stop_o),
        .stop_self_o(stop_self_o), .bus_err_o(bus_err_o),
        .alert_o(alert_o), .busy_o(busy_o)
    );

    i2c_cond_monitor #(.SMBUS_EN(1'b0)) dut_nosmb_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .scl_i(scl), .sda_i(sda),
        .alert_n_i(aln), .is_master_i(m), .stop_by_self_i(sbu),
        .addressed_i(adr), .addr_phase_i(aph), .smb_host_en_i(host),
        .alert_en_i(alen), .start_o(n_start_o), .stop_o(n_stop_o),
        .stop_self_o(n_stop_self_o), .bus_err_o(n_bus_err_o),
        .alert_o(n_alert_o), .busy_o(n_busy_o)
    );

    always @(negedge clk) begin
        if (mon_on) begin
            c_st  += int'(start_o);
            c_sp  += int'(stop_o);
            c_sfu += int'(stop_self_o);
            c_be  += int'(bus_err_o);
            c_al  += int'(alert_o);
        end
        c_nosmb_al += int'(n_alert_o);
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic c, input logic d);
        scl = c;
        sda = d;
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_counts();
        c_st = 0; c_sp = 0; c_sfu = 0; c_be = 0; c_al = 0;
    endtask

    task automatic run_op(input vec_t v);
        m = v.m; sbu = v.sbu; adr = v.adr; aph = v.aph; host = v.host; alen = v.alen;
        clear_counts();
        mon_on = 1'b1;
        unique case (v.op)
            OP_START: begin step(0, 1); step(1, 1); step(1, 0); step(0, 0); end
            OP_STOP:  begin step(0, 0); step(1, 0); step(1, 1); end
            OP_BITS:  for (int i = 0; i < int'(v.nbits); i++) begin
                          step(0, i[0]); step(1, i[0]); step(0, i[0]);
                      end
            OP_ALERT: begin
                          aln = 1'b0; repeat (4) @(negedge clk);
                          aln = 1'b1; repeat (4) @(negedge clk);
                      end
            default: ;
        endcase
        repeat (4) @(negedge clk);
        mon_on = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #500us;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        check("R4 reset busy", int'(busy_o), 0);
        check("R12 reset pulses", int'(start_o | stop_o | stop_self_o | bus_err_o | alert_o), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 latency of START
        sda = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 start before latency", int'(start_o), 0);
        @(negedge clk);
        check("R1 start at third edge", int'(start_o), 1);
        check("R3 busy with start", int'(busy_o), 1);
        @(negedge clk);
        check("R12 start one cycle", int'(start_o), 0);
        step(0, 0);
        step(1, 0);
        // R2 latency of STOP
        sda = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 stop before latency", int'(stop_o), 0);
        @(negedge clk);
        check("R2 stop at third edge", int'(stop_o), 1);
        check("R3 busy drops with stop", int'(busy_o), 0);
        @(negedge clk);
        check("R12 stop one cycle", int'(stop_o), 0);
        repeat (4) @(negedge clk);

        // vector table
        for (int k = 0; k < NVEC; k++) begin
            run_op(VEC[k]);
            check($sformatf("R1 row%0d start count", k), c_st, int'(VEC[k].e_st));
            check($sformatf("R2 row%0d stop count", k), c_sp, int'(VEC[k].e_sp));
            check($sformatf("R8 R9 row%0d stop_self count", k), c_sfu, int'(VEC[k].e_sfu));
            check($sformatf("R6 R7 row%0d bus_err count", k), c_be, int'(VEC[k].e_be));
            check($sformatf("R10 row%0d alert count", k), c_al, int'(VEC[k].e_al));
            check($sformatf("R3 row%0d busy", k), int'(busy_o), int'(VEC[k].e_busy));
        end

        // R4: enable low mid-transfer
        run_op(VEC[3]);
        check("R4 busy before disable", int'(busy_o), 1);
        en = 1'b0;
        repeat (2) @(negedge clk);
        check("R4 busy cleared by disable", int'(busy_o), 0);
        clear_counts();
        mon_on = 1'b1;
        host = 1'b1; alen = 1'b1;
        step(1, 0);
        step(1, 1);
        aln = 1'b0; repeat (4) @(negedge clk);
        aln = 1'b1; repeat (4) @(negedge clk);
        en = 1'b1;
        repeat (6) @(negedge clk);
        mon_on = 1'b0;
        check("R4 no pulses while off", c_st + c_sp + c_sfu + c_be + c_al, 0);
        check("R4 idle after re-enable", int'(busy_o), 0);
        run_op(VEC[3]);
        check("R4 start after re-enable", c_st, 1);
        check("R4 busy after re-enable", int'(busy_o), 1);
        run_op(VEC[5]);
        check("R4 stop after re-enable", c_sfu, 1);

        // R11: variant without SMBus support never alerts
        check("R11 alert tied low", c_nosmb_al, 0);

        finish_run();
    end

endmodule